// File: doc/BRIEF.md
# Streaming Memory Checksum Engine

This block walks a window of a byte-addressed memory and folds every byte it reads into a 16-bit one's-complement checksum of the kind used by Internet protocols. The host loads a start and an end address and sets the checksum-enable bit. It then pulses a set request for the run bit. From the next clock the engine issues one read per cycle through a read port that returns data one cycle after the address. The run bit reads back as busy until the last byte has been folded in. At that point the bit drops, the result appears in two byte-wide registers, and a sticky interrupt flag is raised.

Bytes are taken in pairs counted from the window start, and the byte at the even offset forms the upper half of each 16-bit word. A window of odd length ends with a word whose lower byte is zero. Words are summed with end-around carry, and the stored result is the bitwise complement of that sum. The read rate is fixed at one byte per clock. A writer that fills the same memory at that rate can therefore be followed by this engine started any time after it. The window is walked modulo the 13-bit address space, so an end address below the start address passes through 1FFFh to 0000h. A clear request aborts a run that is in progress.

Top module: `csum_engine`

## Requirements
- R1: After reset, busy and the interrupt flag are 0, the result bytes are 00h, and no read is issued.
- R2: A set request is accepted only while the checksum-enable input is 1. A request made while enable is 0 leaves busy at 0 and issues no read.
- R3: A run of N bytes issues exactly N reads on consecutive cycles. The first read is at the start address, and each later address is one more than the previous, modulo 2^13 (1FFFh is followed by 0000h).
- R4: Bytes are paired from the window start with the even-offset byte as the high byte. Example: 12h 34h 56h 78h gives result 9753h.
- R5: An odd-length window pads its final byte with a zero low byte. Example: 12h 34h 56h 78h 9Ah gives FD52h, and a single byte 9Ah gives 65FFh.
- R6: Word addition uses end-around carry, and the result is the complement of the sum. Example: FFh FFh 00h 01h gives FFFEh.
- R7: A full window 0000h–1FFFh whose bytes hold the low byte of their own address gives F807h.
- R8: Busy is 1 for exactly N+2 clock cycles after the edge that accepts a set request, and the result includes the last byte.
- R9: The interrupt flag rises in the same cycle that busy falls at completion. It stays 1 until an acknowledge pulse clears it.
- R10: A clear request during a run drops busy at the next edge and stops reads. The result bytes and the interrupt flag are left unchanged, and a later run gives a correct result.
- R11: A set request made while busy has no effect on the run in progress: its addresses, latency and result are unchanged.
- R12: The result's bits 7:0 appear on the low-byte output and bits 15:8 appear on the high-byte output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start | input | 13 | First address of the window |
| win_end | input | 13 | Last address of the window (inclusive) |
| sum_enable | input | 1 | Checksum mode enable; must be 1 for a set request to be accepted |
| go_set | input | 1 | Pulse: set the run bit |
| go_clr | input | 1 | Pulse: clear the run bit (abort) |
| irq_ack | input | 1 | Pulse: clear the interrupt flag |
| mem_rd_en | output | 1 | Read strobe to the memory |
| mem_rd_addr | output | 13 | Read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| go_busy | output | 1 | Run bit readback; clears itself at completion |
| irq_flag | output | 1 | Sticky completion flag |
| sum_lo | output | 8 | Result bits 7:0 |
| sum_hi | output | 8 | Result bits 15:8 |

## Verification
The hardest case to reach from the ports is the pipeline tail. The last read returns its byte one cycle after the final address, and the completion flag must wait for that byte. On top of that, the parity of the window length decides whether the byte is padded or joined with a held partner. The bench reaches this case with windows of one, four and five bytes, a window with an odd start address, and a window that crosses the top of the address space. For each run it checks the exact busy length against N+2 and a result computed independently. An abort partway through a long run, followed at once by a short run, shows that no partial state survives into the next checksum.

// File: rtl/csum_pkg.sv
package csum_pkg;

    localparam int SUM_W = 16;

    // One's-complement addition: carry out of bit 15 is folded back into bit 0.
    function automatic logic [SUM_W-1:0] oc_add(input logic [SUM_W-1:0] a,
                                                input logic [SUM_W-1:0] b);
        logic [SUM_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, s[SUM_W]};
    endfunction

endpackage

// File: rtl/csum_addr_gen.sv
module csum_addr_gen #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          abort,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          rd_last
);

    typedef struct packed {
        logic          active;
        logic [AW-1:0] addr;
        logic [AW-1:0] stop;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  at_end;

    assign at_end  = walk_q.addr == walk_q.stop;
    assign rd_en   = walk_q.active;
    assign rd_addr = walk_q.addr;
    assign rd_last = walk_q.active && at_end;

    always_comb begin
        walk_d = walk_q;
        if (abort) begin
            walk_d.active = 1'b0;
        end else if (launch) begin
            walk_d.active = 1'b1;
            walk_d.addr   = first_addr;
            walk_d.stop   = last_addr;
        end else if (walk_q.active) begin
            if (at_end) walk_d.active = 1'b0;
            else        walk_d.addr   = walk_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    // R3: consecutive reads step the address by one
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_last && !abort) |=> (rd_en && rd_addr == $past(rd_addr) + AW'(1)));

    // R3: a run ends right after its last read
    assert_stop_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_last && !launch) |=> !rd_en);

endmodule

// File: rtl/csum_accum.sv
module csum_accum
    import csum_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             abort,
    input  logic             rd_en,
    input  logic             rd_last,
    input  logic [7:0]       rd_data,
    output logic             sum_fin,
    output logic [SUM_W-1:0] sum_val
);

    typedef struct packed {
        logic             vld;
        logic             last;
        logic             odd;
        logic [7:0]       hi;
        logic [SUM_W-1:0] acc;
        logic             fin;
    } acc_t;

    acc_t acc_d, acc_q;

    assign sum_fin = acc_q.fin;
    assign sum_val = acc_q.acc;

    always_comb begin
        acc_d      = acc_q;
        acc_d.fin  = 1'b0;
        acc_d.vld  = rd_en;
        acc_d.last = rd_last;
        if (abort) begin
            acc_d.vld  = 1'b0;
            acc_d.last = 1'b0;
        end else begin
            if (clear) begin
                acc_d.acc = '0;
                acc_d.odd = 1'b0;
            end
            if (acc_q.vld) begin
                if (!acc_q.odd) begin
                    if (acc_q.last) begin
                        acc_d.acc = oc_add(acc_q.acc, {rd_data, 8'h00});
                        acc_d.fin = 1'b1;
                    end else begin
                        acc_d.hi  = rd_data;
                        acc_d.odd = 1'b1;
                    end
                end else begin
                    acc_d.acc = oc_add(acc_q.acc, {acc_q.hi, rd_data});
                    acc_d.odd = 1'b0;
                    acc_d.fin = acc_q.last;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R8: completion follows a data beat and lasts one cycle
    assert_fin_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sum_fin |-> ($past(acc_q.vld) && $past(acc_q.last)));

    assert_fin_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sum_fin |=> !sum_fin);

endmodule

// File: rtl/csum_engine.sv
module csum_engine
    import csum_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] win_start,
    input  logic [AW-1:0] win_end,
    input  logic          sum_enable,
    input  logic          go_set,
    input  logic          go_clr,
    input  logic          irq_ack,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    output logic          go_busy,
    output logic          irq_flag,
    output logic [7:0]    sum_lo,
    output logic [7:0]    sum_hi
);

    typedef struct packed {
        logic             run;
        logic             irq;
        logic [SUM_W-1:0] result;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             launch;
    logic             abort;
    logic             rd_last;
    logic             sum_fin;
    logic [SUM_W-1:0] sum_val;

    assign launch = go_set && sum_enable && !ctl_q.run && !go_clr;
    assign abort  = go_clr && ctl_q.run;

    csum_addr_gen #(.AW(AW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .abort      (abort),
        .first_addr (win_start),
        .last_addr  (win_end),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_rd_addr),
        .rd_last    (rd_last)
    );

    csum_accum u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .abort   (abort),
        .rd_en   (mem_rd_en),
        .rd_last (rd_last),
        .rd_data (mem_rd_data),
        .sum_fin (sum_fin),
        .sum_val (sum_val)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (irq_ack) ctl_d.irq = 1'b0;
        if (launch) begin
            ctl_d.run = 1'b1;
        end else if (abort) begin
            ctl_d.run = 1'b0;
        end else if (sum_fin && ctl_q.run) begin
            ctl_d.run    = 1'b0;
            ctl_d.irq    = 1'b1;
            ctl_d.result = ~sum_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign go_busy  = ctl_q.run;
    assign irq_flag = ctl_q.irq;
    assign sum_lo   = ctl_q.result[7:0];
    assign sum_hi   = ctl_q.result[SUM_W-1:8];

    // R2: a run only starts with checksum mode enabled
    assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_busy) |-> $past(sum_enable));

    // R10: reads only happen while the run bit is set
    assert_read_in_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> go_busy);

    // R8: busy ends only on completion or abort
    assert_busy_end_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go_busy) |-> ($past(go_clr) || $past(sum_fin)));

    // R9: the flag rises only on completion
    assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($past(sum_fin) && $fell(go_busy)));

    // R10: result changes only at completion
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_fin |=> $stable({sum_hi, sum_lo}));

endmodule

// File: tb/sim_csum_engine.sv
module sim_csum_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] win_start = '0;
    logic [12:0] win_end = '0;
    logic        sum_enable = 1'b0;
    logic        go_set = 1'b0;
    logic        go_clr = 1'b0;
    logic        irq_ack = 1'b0;
    logic        mem_rd_en;
    logic [12:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        go_busy;
    logic        irq_flag;
    logic [7:0]  sum_lo;
    logic [7:0]  sum_hi;

    int total = 0;
    int bad = 0;

    logic [7:0]  mem [0:8191];
    logic [15:0] exp_q[$];
    logic [12:0] exp_base = '0;
    int          rd_count = 0;
    int          addr_err = 0;
    logic        irq_prev = 1'b0;

    always #2.5 clk = ~clk;

    csum_engine u0 (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
        .sum_enable(sum_enable), .go_set(go_set), .go_clr(go_clr), .irq_ack(irq_ack),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .go_busy(go_busy), .irq_flag(irq_flag), .sum_lo(sum_lo), .sum_hi(sum_hi)
    );

    // memory with one cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    // address monitor (R3)
    always @(posedge clk) begin
        if (go_set && !go_busy && sum_enable) rd_count <= 0;
        else if (mem_rd_en) begin
            if (mem_rd_addr !== exp_base + 13'(rd_count)) addr_err <= addr_err + 1;
            rd_count <= rd_count + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compare each completed result (R12)
    always @(negedge clk) begin
        if (rst_n && irq_flag && !irq_prev) begin
            if (exp_q.size() == 0) check(1'b0, "R9 unexpected completion", 32'(irq_flag), 32'd0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(sum_lo == e[7:0],  "R12 low byte",  32'(sum_lo), 32'(e[7:0]));
                check(sum_hi == e[15:8], "R12 high byte", 32'(sum_hi), 32'(e[15:8]));
            end
        end
        irq_prev <= irq_flag;
    end

    function automatic logic [15:0] model(input logic [12:0] s, input logic [12:0] e);
        logic [31:0] acc = 0;
        int n = int'(13'(e - s)) + 1;
        for (int i = 0; i < n; i += 2) begin
            logic [7:0] h, l;
            h = mem[13'(s + 13'(i))];
            l = (i + 1 < n) ? mem[13'(s + 13'(i + 1))] : 8'h00;
            acc += {16'd0, h, l};
        end
        while (acc[31:16] != 0) acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
        return ~acc[15:0];
    endfunction

    task automatic pulse_set();
        @(negedge clk) go_set = 1'b1;
        @(negedge clk) go_set = 1'b0;
    endtask

    task automatic ack_irq();
        @(negedge clk) irq_ack = 1'b1;
        @(negedge clk) irq_ack = 1'b0;
    endtask

    // driver: push expectation, run, check latency and reads
    task automatic run_case(input logic [12:0] s, input logic [12:0] e, input bit poke, output logic [15:0] got);
        int n = int'(13'(e - s)) + 1;
        int cyc = 0;
        int err0 = addr_err;
        exp_q.push_back(model(s, e));
        win_start = s; win_end = e; exp_base = s;
        pulse_set();
        while (go_busy && cyc < 9000) begin
            cyc++;
            if (poke && cyc == 3) go_set = 1'b1;      // R11 request while busy
            else go_set = 1'b0;
            @(negedge clk);
        end
        go_set = 1'b0;
        check(cyc == n + 2, "R8 busy length", 32'(cyc), 32'(n + 2));
        check(rd_count == n && addr_err == err0, "R3 read count/addresses", 32'(rd_count), 32'(n));
        check(irq_flag == 1'b1, "R9 flag at completion", 32'(irq_flag), 32'd1);
        got = {sum_hi, sum_lo};
        ack_irq();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [15:0] keep;
        for (int i = 0; i < 8192; i++) mem[i] = 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!go_busy && !irq_flag && !mem_rd_en, "R1 reset controls", {go_busy, irq_flag, mem_rd_en}, 0);
        check({sum_hi, sum_lo} == 16'h0000, "R1 reset result", {sum_hi, sum_lo}, 0);

        // R2: enable low ignores the request
        pulse_set();
        check(!go_busy && !mem_rd_en, "R2 disabled request", {go_busy, mem_rd_en}, 0);
        repeat (3) @(negedge clk);
        check(!go_busy && !irq_flag, "R2 still idle", {go_busy, irq_flag}, 0);
        sum_enable = 1'b1;

        // R7: full address-fill window
        run_case(13'h0000, 13'h1FFF, 1'b0, r);
        check(r == 16'hF807, "R7 address fill", r, 16'hF807);

        // R4/R5/R6 small windows
        mem[13'h100] = 8'h12; mem[13'h101] = 8'h34; mem[13'h102] = 8'h56;
        mem[13'h103] = 8'h78; mem[13'h104] = 8'h9A;
        run_case(13'h100, 13'h103, 1'b0, r);
        check(r == 16'h9753, "R4 even-offset high byte", r, 16'h9753);
        run_case(13'h100, 13'h104, 1'b0, r);
        check(r == 16'hFD52, "R5 odd length pad", r, 16'hFD52);
        run_case(13'h104, 13'h104, 1'b0, r);
        check(r == 16'h65FF, "R5 single byte", r, 16'h65FF);
        run_case(13'h101, 13'h102, 1'b0, r);
        check(r == 16'hCBA9, "R4 odd start address", r, 16'hCBA9);
        mem[13'h200] = 8'hFF; mem[13'h201] = 8'hFF; mem[13'h202] = 8'h00; mem[13'h203] = 8'h01;
        run_case(13'h200, 13'h203, 1'b0, r);
        check(r == 16'hFFFE, "R6 end-around carry", r, 16'hFFFE);

        // R3: window across the top of the address space
        run_case(13'h1FFE, 13'h0001, 1'b0, r);
        check(r == 16'h00FF, "R3 wrap window", r, 16'h00FF);

        // R11: request while busy is ignored
        for (int i = 0; i < 40; i++) mem[13'h300 + 13'(i)] = 8'((i * 37 + 11) ^ (i << 3));
        run_case(13'h300, 13'h326, 1'b1, r);
        check(r == model(13'h300, 13'h326), "R11 busy request ignored", r, model(13'h300, 13'h326));

        // R9: flag holds until acknowledged
        exp_q.push_back(model(13'h100, 13'h103));
        win_start = 13'h100; win_end = 13'h103; exp_base = 13'h100;
        pulse_set();
        repeat (10) @(negedge clk);
        check(irq_flag == 1'b1, "R9 flag holds", 32'(irq_flag), 1);
        ack_irq();
        check(irq_flag == 1'b0, "R9 flag cleared by ack", 32'(irq_flag), 0);

        // R10: abort partway through a long run
        keep = {sum_hi, sum_lo};
        win_start = 13'h0000; win_end = 13'h1FFF;
        pulse_set();
        repeat (20) @(negedge clk);
        go_clr = 1'b1;
        @(negedge clk) go_clr = 1'b0;
        check(!go_busy && !mem_rd_en, "R10 abort stops run", {go_busy, mem_rd_en}, 0);
        repeat (5) @(negedge clk);
        check(!irq_flag && {sum_hi, sum_lo} == keep, "R10 result/flag unchanged", {sum_hi, sum_lo}, keep);
        run_case(13'h100, 13'h104, 1'b0, r);
        check(r == 16'hFD52, "R10 run after abort", r, 16'hFD52);

        check(exp_q.size() == 0, "R12 all results seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule